// File: doc/BRIEF.md
# Disk Head Positioning Sequencer

This block carries out the head-movement commands of a floppy disk controller. A command names one of five operations: return to track zero, seek to a target track, repeat the last step direction, step inward, or step outward. It also carries an update flag, a head-load flag, a verify flag and a two-bit step-rate code. The block drives the drive's step and direction lines and keeps its own track register. It checks the track-zero sense line during a return to zero. It reports completion through a busy flag and an interrupt line, and it raises a seek-error flag and a CRC-error flag when something goes wrong.

When verification is requested, the block waits at the end of the movement for decoded ID fields from an external field reader. Each field carries a track byte and a CRC-valid bit. The block compares the track byte with its track register. While it waits, it counts rising edges of a synchronised index input so that it can give up after four disk revolutions.

ID fields arrive on a valid/ready stream. `id_ready` is high only while the block is waiting for a field. A field moves on a clock edge where `id_valid` and `id_ready` are both high. The reader must hold `id_valid`, `id_track` and `id_crc_ok` steady until that edge, and the block never stalls a field that is offered while it is waiting. All other pins are plain levels or single-cycle strobes.

Top module: `head_pos_seq`

## Requirements
- R1: A command is accepted only when `cmd_valid` is high while the block is idle and `cmd_op` is one of 0 = restore, 1 = seek, 2 = step (last direction), 3 = step in, 4 = step out. On acceptance `busy` rises on the next cycle. Codes 5 to 7, and any command offered while busy, are ignored: they produce no step pulse and no busy.
- R2: Each step pulse lasts exactly `PULSE_DD_CYC` cycles when `dbl_density` is 1 and `PULSE_SD_CYC` cycles when it is 0. `dir` never changes while `step` is high, and it has held its value for at least `DIR_SETUP_CYC` cycles when `step` rises.
- R3: `dir` is 1 for moves toward higher track numbers and 0 for moves toward track zero. Step-in uses 1 and step-out uses 0. A plain step reuses the direction of the previous movement, which is 1 after reset.
- R4: A restore that finds `tr00_n` low at its start sets the track register to 0 and completes without any step pulse.
- R5: Otherwise, a restore steps outward until `tr00_n` is seen low and then sets the track register to 0. If 255 steps go by without that happening, it stops, sets `seek_err` and completes.
- R6: A seek steps toward `target_trk` and moves the track register by one per step until the two are equal. If they are already equal, no pulse is issued.
- R7: Step, step-in and step-out each issue exactly one pulse. They change the track register by one in the step direction only when the update flag is 1.
- R8: Rate codes 0 to 3 select gaps of `GAP0_CYC` to `GAP3_CYC` cycles. The low time between successive pulses of one command equals the selected gap plus a fixed overhead, so it differs between two rates by exactly the difference of their gaps.
- R9: With verify set, an ID field with good CRC and a track byte equal to the track register completes the command without an error. An ID field with good CRC and a different track byte sets `seek_err` and completes the command.
- R10: An ID field with bad CRC sets `crc_err`, and the block keeps waiting. If four index rising edges are counted while waiting, the block sets `seek_err` and completes. An ID field accepted in the same cycle as the fourth edge takes precedence.
- R11: `id_ready` is low except while waiting for an ID field. Fields offered at other times are not consumed and change nothing.
- R12: At completion `busy` falls and `irq` rises in the same cycle. `irq` clears on `stat_rd` or on an accepted command, and both error flags clear when a command is accepted.
- R13: `head_load` is high while a command that carried the head-load flag is busy, and low otherwise.
- R14: `trk_wr` loads the track register from `trk_wdata` while idle and is ignored while busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Operation code |
| cmd_update | input | 1 | Update track register on single steps |
| cmd_hload | input | 1 | Load head for the command |
| cmd_verify | input | 1 | Verify position after movement |
| cmd_rate | input | 2 | Step gap select |
| dbl_density | input | 1 | 1 selects the short step pulse |
| trk_wr | input | 1 | Track register write strobe |
| trk_wdata | input | TRK_W | Track register write value |
| target_trk | input | TRK_W | Seek target track |
| stat_rd | input | 1 | Status read strobe, clears irq |
| tr00_n | input | 1 | Track-zero sense, active low |
| index_raw | input | 1 | Asynchronous index pulse |
| id_valid | input | 1 | ID field offered |
| id_ready | output | 1 | ID field can be taken |
| id_track | input | TRK_W | Track byte of the ID field |
| id_crc_ok | input | 1 | ID field CRC was valid |
| step | output | 1 | Step pulse to the drive |
| dir | output | 1 | Step direction, 1 = inward |
| head_load | output | 1 | Head load request |
| track | output | TRK_W | Track register |
| busy | output | 1 | Command in progress |
| seek_err | output | 1 | Seek error flag |
| crc_err | output | 1 | ID CRC error flag |
| irq | output | 1 | Completion interrupt |

## Verification
Two events can land on the same clock edge while the block waits to verify: it can accept an ID field, and it can count the fourth index edge. The bench issues three index pulses and then raises the index line for a fourth. It counts the synchroniser and edge-detector stages so that a good, matching field is first offered in exactly the cycle where the revolution limit is reached. The command must then complete without `seek_err`, because the field wins. A separate run lets the fourth edge arrive with no field offered and expects a seek error.

// File: rtl/hps_pkg.sv
package hps_pkg;

  typedef enum logic [2:0] {
    OP_RESTORE  = 3'd0,
    OP_SEEK     = 3'd1,
    OP_STEP     = 3'd2,
    OP_STEP_IN  = 3'd3,
    OP_STEP_OUT = 3'd4
  } hps_op_e;

  typedef enum logic [1:0] {
    SG_IDLE,
    SG_SETUP,
    SG_PULSE,
    SG_GAP
  } sg_state_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RST_CHK,
    S_SEEK_CMP,
    S_ISSUE,
    S_WAIT,
    S_VERIFY,
    S_FINISH
  } hps_state_e;

endpackage

// File: rtl/hps_step_gen.sv
module hps_step_gen
  import hps_pkg::*;
#(
  parameter int DIR_SETUP_CYC = 24,
  parameter int PULSE_DD_CYC  = 4,
  parameter int PULSE_SD_CYC  = 8,
  parameter int GAP0_CYC      = 12000,
  parameter int GAP1_CYC      = 24000,
  parameter int GAP2_CYC      = 40000,
  parameter int GAP3_CYC      = 60000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       dir_in,
  input  logic       dbl_density,
  input  logic [1:0] rate,
  output logic       step,
  output logic       dir,
  output logic       done
);

  localparam int M01   = (GAP0_CYC > GAP1_CYC) ? GAP0_CYC : GAP1_CYC;
  localparam int M23   = (GAP2_CYC > GAP3_CYC) ? GAP2_CYC : GAP3_CYC;
  localparam int MG    = (M01 > M23) ? M01 : M23;
  localparam int MP    = (PULSE_DD_CYC > PULSE_SD_CYC) ? PULSE_DD_CYC : PULSE_SD_CYC;
  localparam int MS    = (DIR_SETUP_CYC > MP) ? DIR_SETUP_CYC : MP;
  localparam int MAXV  = (MG > MS) ? MG : MS;
  localparam int CNT_W = $clog2(MAXV + 1);

  localparam logic [CNT_W-1:0] SETUP_M1 = CNT_W'(DIR_SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] PDD_M1   = CNT_W'(PULSE_DD_CYC - 1);
  localparam logic [CNT_W-1:0] PSD_M1   = CNT_W'(PULSE_SD_CYC - 1);

  sg_state_e        st;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] gap_m1;
  logic             dir_q;

  always_comb begin
    case (rate)
      2'd0:    gap_m1 = CNT_W'(GAP0_CYC - 1);
      2'd1:    gap_m1 = CNT_W'(GAP1_CYC - 1);
      2'd2:    gap_m1 = CNT_W'(GAP2_CYC - 1);
      default: gap_m1 = CNT_W'(GAP3_CYC - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= SG_IDLE;
      cnt   <= '0;
      dir_q <= 1'b1;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        SG_IDLE: if (start) begin
          dir_q <= dir_in;
          cnt   <= SETUP_M1;
          st    <= SG_SETUP;
        end
        SG_SETUP: if (cnt == '0) begin
          cnt <= dbl_density ? PDD_M1 : PSD_M1;
          st  <= SG_PULSE;
        end else cnt <= cnt - 1'b1;
        SG_PULSE: if (cnt == '0) begin
          cnt <= gap_m1;
          st  <= SG_GAP;
        end else cnt <= cnt - 1'b1;
        default: if (cnt == '0) begin
          st   <= SG_IDLE;
          done <= 1'b1;
        end else cnt <= cnt - 1'b1;
      endcase
    end
  end

  assign step = (st == SG_PULSE);
  assign dir  = dir_q;

  AST_DIR_HELD_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> $stable(dir)); // R2

  AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (st == SG_IDLE) && !step); // R2

endmodule

// File: rtl/hps_rev_counter.sv
module hps_rev_counter #(
  parameter int REV_LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic index_raw,
  input  logic enable,
  output logic hit
);

  localparam int RW = $clog2(REV_LIMIT + 1);

  logic          sync0, sync1, prev;
  logic          rise;
  logic [RW-1:0] count;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync0 <= 1'b0;
      sync1 <= 1'b0;
      prev  <= 1'b0;
    end else begin
      sync0 <= index_raw;
      sync1 <= sync0;
      prev  <= sync1;
    end
  end

  assign rise = sync1 & ~prev;

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) count <= '0;
    else if (rise && count != RW'(REV_LIMIT)) count <= count + 1'b1;
  end

  assign hit = (count == RW'(REV_LIMIT));

  AST_REV_COUNT_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (count != $past(count)) |-> (count == '0 || count == $past(count) + 1'b1)); // R10

endmodule

// File: rtl/head_pos_seq.sv
module head_pos_seq
  import hps_pkg::*;
#(
  parameter int TRK_W         = 8,
  parameter int MAX_RESTORE   = 255,
  parameter int REV_LIMIT     = 4,
  parameter int CLK_PER_US    = 2,
  parameter int DIR_SETUP_CYC = 12 * CLK_PER_US,
  parameter int PULSE_DD_CYC  = 2 * CLK_PER_US,
  parameter int PULSE_SD_CYC  = 4 * CLK_PER_US,
  parameter int GAP0_CYC      = 6000 * CLK_PER_US,
  parameter int GAP1_CYC      = 12000 * CLK_PER_US,
  parameter int GAP2_CYC      = 20000 * CLK_PER_US,
  parameter int GAP3_CYC      = 30000 * CLK_PER_US
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic             cmd_update,
  input  logic             cmd_hload,
  input  logic             cmd_verify,
  input  logic [1:0]       cmd_rate,
  input  logic             dbl_density,
  input  logic             trk_wr,
  input  logic [TRK_W-1:0] trk_wdata,
  input  logic [TRK_W-1:0] target_trk,
  input  logic             stat_rd,
  input  logic             tr00_n,
  input  logic             index_raw,
  input  logic             id_valid,
  output logic             id_ready,
  input  logic [TRK_W-1:0] id_track,
  input  logic             id_crc_ok,
  output logic             step,
  output logic             dir,
  output logic             head_load,
  output logic [TRK_W-1:0] track,
  output logic             busy,
  output logic             seek_err,
  output logic             crc_err,
  output logic             irq
);

  localparam int SC_W = $clog2(MAX_RESTORE + 1);
  localparam logic [SC_W-1:0] SC_MAX = SC_W'(MAX_RESTORE);

  hps_state_e       st;
  hps_op_e          op_q;
  logic             upd_q, hld_q, vfy_q;
  logic [1:0]       rate_q;
  logic             dir_want;
  logic [TRK_W-1:0] trk_q;
  logic [SC_W-1:0]  step_cnt;
  logic             seek_err_q, crc_err_q, irq_q;
  logic             cmd_ok, sg_start, sg_done, rev_hit, id_fire, moves_trk;

  assign cmd_ok    = cmd_valid && (st == S_IDLE) && (cmd_op <= 3'd4);
  assign sg_start  = (st == S_ISSUE);
  assign id_ready  = (st == S_VERIFY);
  assign id_fire   = id_valid && id_ready;
  assign moves_trk = (op_q == OP_SEEK) || ((op_q != OP_RESTORE) && upd_q);

  hps_step_gen #(
    .DIR_SETUP_CYC(DIR_SETUP_CYC), .PULSE_DD_CYC(PULSE_DD_CYC),
    .PULSE_SD_CYC(PULSE_SD_CYC), .GAP0_CYC(GAP0_CYC), .GAP1_CYC(GAP1_CYC),
    .GAP2_CYC(GAP2_CYC), .GAP3_CYC(GAP3_CYC)
  ) u_step_gen (
    .clk(clk), .rst_n(rst_n), .start(sg_start), .dir_in(dir_want),
    .dbl_density(dbl_density), .rate(rate_q), .step(step), .dir(dir),
    .done(sg_done)
  );

  hps_rev_counter #(.REV_LIMIT(REV_LIMIT)) u_rev_counter (
    .clk(clk), .rst_n(rst_n), .index_raw(index_raw),
    .enable(st == S_VERIFY), .hit(rev_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      op_q       <= OP_RESTORE;
      upd_q      <= 1'b0;
      hld_q      <= 1'b0;
      vfy_q      <= 1'b0;
      rate_q     <= 2'd0;
      dir_want   <= 1'b1;
      trk_q      <= '0;
      step_cnt   <= '0;
      seek_err_q <= 1'b0;
      crc_err_q  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (trk_wr) trk_q <= trk_wdata;
          if (cmd_ok) begin
            op_q       <= hps_op_e'(cmd_op);
            upd_q      <= cmd_update;
            hld_q      <= cmd_hload;
            vfy_q      <= cmd_verify;
            rate_q     <= cmd_rate;
            seek_err_q <= 1'b0;
            crc_err_q  <= 1'b0;
            step_cnt   <= '0;
            case (hps_op_e'(cmd_op))
              OP_RESTORE:  st <= S_RST_CHK;
              OP_SEEK:     st <= S_SEEK_CMP;
              OP_STEP_IN:  begin dir_want <= 1'b1; st <= S_ISSUE; end
              OP_STEP_OUT: begin dir_want <= 1'b0; st <= S_ISSUE; end
              default:     st <= S_ISSUE;
            endcase
          end
        end
        S_RST_CHK: begin
          if (!tr00_n) begin
            trk_q <= '0;
            st    <= vfy_q ? S_VERIFY : S_FINISH;
          end else if (step_cnt == SC_MAX) begin
            seek_err_q <= 1'b1;
            st         <= S_FINISH;
          end else begin
            dir_want <= 1'b0;
            st       <= S_ISSUE;
          end
        end
        S_SEEK_CMP: begin
          if (trk_q == target_trk) st <= vfy_q ? S_VERIFY : S_FINISH;
          else begin
            dir_want <= (target_trk > trk_q);
            st       <= S_ISSUE;
          end
        end
        S_ISSUE: st <= S_WAIT;
        S_WAIT: if (sg_done) begin
          if (step_cnt != SC_MAX) step_cnt <= step_cnt + 1'b1;
          if (moves_trk) trk_q <= dir_want ? trk_q + 1'b1 : trk_q - 1'b1;
          case (op_q)
            OP_RESTORE: st <= S_RST_CHK;
            OP_SEEK:    st <= S_SEEK_CMP;
            default:    st <= vfy_q ? S_VERIFY : S_FINISH;
          endcase
        end
        S_VERIFY: begin
          if (id_fire) begin
            if (!id_crc_ok) crc_err_q <= 1'b1;
            else begin
              if (id_track != trk_q) seek_err_q <= 1'b1;
              st <= S_FINISH;
            end
          end else if (rev_hit) begin
            seek_err_q <= 1'b1;
            st         <= S_FINISH;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else if (st == S_FINISH) irq_q <= 1'b1;
    else if (stat_rd || cmd_ok) irq_q <= 1'b0;
  end

  assign busy      = (st != S_IDLE);
  assign head_load = busy && hld_q;
  assign track     = trk_q;
  assign seek_err  = seek_err_q;
  assign crc_err   = crc_err_q;
  assign irq       = irq_q;

  AST_STEP_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> busy); // R1

  AST_READY_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    id_ready |-> busy); // R11

  AST_DONE_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> irq); // R12

  AST_TRK_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !trk_wr) |=> $stable(track)); // R14

  AST_TRK_MOVES_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && track != $past(track)) |->
      (track == $past(track) + 1'b1 || track == $past(track) - 1'b1 || track == '0)); // R6

endmodule

// File: tb/head_pos_seq_bench.sv
module head_pos_seq_bench;

  localparam int DS  = 3;
  localparam int PDD = 2;
  localparam int PSD = 4;
  localparam int G0  = 8;
  localparam int G1  = 10;
  localparam int G2  = 14;
  localparam int G3  = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic       cmd_update = 1'b0, cmd_hload = 1'b0, cmd_verify = 1'b0;
  logic [1:0] cmd_rate = 2'd0;
  logic       dbl_density = 1'b1;
  logic       trk_wr = 1'b0;
  logic [7:0] trk_wdata = 8'd0, target_trk = 8'd0;
  logic       stat_rd = 1'b0;
  logic       tr00_n;
  logic       index_raw = 1'b0;
  logic       id_valid = 1'b0;
  logic       id_ready;
  logic [7:0] id_track = 8'd0;
  logic       id_crc_ok = 1'b0;
  logic       step, dir, head_load, busy, seek_err, crc_err, irq;
  logic [7:0] track;

  int checks = 0, fails = 0, cyc = 0;
  int pulses = 0, hi_run = 0, last_width = 0, low_run = 0, last_low = 0;
  int dir_age = 0, setup_bad = 0, dirchg_bad = 0, pos = 0;
  logic step_p = 1'b0, dir_p = 1'b1, no_t0 = 1'b0;

  assign tr00_n = no_t0 ? 1'b1 : (pos != 0);

  always #2 clk = ~clk;

  head_pos_seq #(
    .DIR_SETUP_CYC(DS), .PULSE_DD_CYC(PDD), .PULSE_SD_CYC(PSD),
    .GAP0_CYC(G0), .GAP1_CYC(G1), .GAP2_CYC(G2), .GAP3_CYC(G3)
  ) u_head_pos_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_update(cmd_update), .cmd_hload(cmd_hload), .cmd_verify(cmd_verify),
    .cmd_rate(cmd_rate), .dbl_density(dbl_density), .trk_wr(trk_wr),
    .trk_wdata(trk_wdata), .target_trk(target_trk), .stat_rd(stat_rd),
    .tr00_n(tr00_n), .index_raw(index_raw), .id_valid(id_valid),
    .id_ready(id_ready), .id_track(id_track), .id_crc_ok(id_crc_ok),
    .step(step), .dir(dir), .head_load(head_load), .track(track),
    .busy(busy), .seek_err(seek_err), .crc_err(crc_err), .irq(irq)
  );

  // drive model and pulse monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (dir !== dir_p) begin
        dir_age = 0;
        if (step) dirchg_bad++;
      end else dir_age++;
      if (step && !step_p) begin
        pulses++;
        last_low = low_run;
        low_run = 0;
        if (dir_age < DS) setup_bad++;
        if (dir) pos++;
        else if (pos > 0) pos--;
      end
      if (step) hi_run++;
      else begin
        if (step_p) last_width = hi_run;
        hi_run = 0;
        low_run++;
      end
      step_p = step;
      dir_p = dir;
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 150000)", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_cmd(input int op, input bit u, input bit h, input bit v, input int rate);
    @(negedge clk);
    pulses = 0;
    cmd_op = 3'(op); cmd_update = u; cmd_hload = h; cmd_verify = v;
    cmd_rate = 2'(rate); cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 2000 && !id_ready; i++) @(negedge clk);
  endtask

  task automatic write_trk(input int v);
    @(negedge clk);
    trk_wr = 1'b1; trk_wdata = 8'(v);
    @(negedge clk);
    trk_wr = 1'b0;
  endtask

  task automatic present_id(input int t, input bit ok);
    @(negedge clk);
    id_valid = 1'b1; id_track = 8'(t); id_crc_ok = ok;
    for (int i = 0; i < 2000 && !id_ready; i++) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    id_valid = 1'b0;
  endtask

  task automatic index_pulse();
    @(negedge clk);
    index_raw = 1'b1;
    repeat (3) @(negedge clk);
    index_raw = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(busy == 1'b0 && irq == 1'b0, "R12 reset idle", int'(busy), 0);
    chk(step == 1'b0 && id_ready == 1'b0, "R11 reset outputs low", int'(id_ready), 0);
    chk(track == 8'd0, "R14 reset track", int'(track), 0);
  endtask

  task automatic t_restore_at_zero();
    pos = 0;
    write_trk(7);
    chk(track == 8'd7, "R14 idle track write", int'(track), 7);
    do_cmd(0, 0, 0, 0, 0);
    wait_done();
    chk(pulses == 0, "R4 no steps at track zero", pulses, 0);
    chk(track == 8'd0, "R4 track cleared", int'(track), 0);
    chk(irq == 1'b1, "R12 irq on completion", int'(irq), 1);
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
    chk(irq == 1'b0, "R12 status read clears irq", int'(irq), 0);
  endtask

  task automatic t_restore_steps();
    pos = 3;
    write_trk(9);
    dbl_density = 1'b1;
    do_cmd(0, 0, 0, 0, 0);
    wait_done();
    chk(pulses == 3, "R5 restore step count", pulses, 3);
    chk(track == 8'd0 && pos == 0, "R5 restore reaches zero", int'(track), 0);
    chk(seek_err == 1'b0, "R5 no seek error", int'(seek_err), 0);
    chk(dir == 1'b0, "R3 restore steps outward", int'(dir), 0);
    chk(last_width == PDD, "R2 double density pulse width", last_width, PDD);
  endtask

  task automatic t_restore_fail();
    no_t0 = 1'b1;
    pos = 100;
    do_cmd(0, 0, 0, 0, 0);
    chk(irq == 1'b0, "R12 new command clears irq", int'(irq), 0);
    wait_done();
    chk(pulses == 255, "R5 restore bound", pulses, 255);
    chk(seek_err == 1'b1, "R5 seek error after bound", int'(seek_err), 1);
    no_t0 = 1'b0;
  endtask

  task automatic t_seek();
    int low0;
    pos = 0;
    write_trk(0);
    target_trk = 8'd2;
    do_cmd(1, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    trk_wr = 1'b1; trk_wdata = 8'h55;
    cmd_valid = 1'b1; cmd_op = 3'd0;
    @(negedge clk);
    trk_wr = 1'b0; cmd_valid = 1'b0;
    wait_done();
    low0 = last_low;
    chk(pulses == 2, "R1 busy command ignored", pulses, 2);
    chk(track == 8'd2 && pos == 2, "R6 seek inward", int'(track), 2);
    chk(track == 8'd2, "R14 busy write ignored", int'(track), 2);
    chk(low0 >= G0 + DS, "R8 gap at least rate 0", low0, G0 + DS);
    target_trk = 8'd0;
    do_cmd(1, 0, 0, 0, 3);
    wait_done();
    chk(track == 8'd0 && pos == 0, "R6 seek outward", int'(track), 0);
    chk(dir == 1'b0, "R3 seek outward direction", int'(dir), 0);
    chk(last_low - low0 == G3 - G0, "R8 rate 3 vs rate 0 gap", last_low - low0, G3 - G0);
    do_cmd(1, 0, 0, 0, 0);
    wait_done();
    chk(pulses == 0 && irq == 1'b1, "R6 seek already on target", pulses, 0);
  endtask

  task automatic t_bad_op();
    do_cmd(5, 0, 0, 0, 0);
    chk(busy == 1'b0, "R1 code 5 ignored", int'(busy), 0);
    repeat (5) @(negedge clk);
    chk(busy == 1'b0 && pulses == 0, "R1 code 5 no activity", pulses, 0);
  endtask

  task automatic t_single_steps();
    pos = 10;
    write_trk(10);
    dbl_density = 1'b0;
    do_cmd(3, 1, 1, 0, 1);
    chk(head_load == 1'b1, "R13 head load while busy", int'(head_load), 1);
    wait_done();
    chk(head_load == 1'b0, "R13 head load drops", int'(head_load), 0);
    chk(pulses == 1 && track == 8'd11, "R7 step in with update", int'(track), 11);
    chk(dir == 1'b1 && pos == 11, "R3 step in direction", int'(dir), 1);
    chk(last_width == PSD, "R2 single density pulse width", last_width, PSD);
    do_cmd(4, 0, 0, 0, 2);
    chk(head_load == 1'b0, "R13 no head load without flag", int'(head_load), 0);
    wait_done();
    chk(pulses == 1 && track == 8'd11 && pos == 10, "R7 step out without update", int'(track), 11);
    do_cmd(2, 1, 0, 0, 0);
    wait_done();
    chk(dir == 1'b0 && pos == 9, "R3 plain step keeps last direction", pos, 9);
    chk(track == 8'd10, "R7 plain step with update", int'(track), 10);
    dbl_density = 1'b1;
  endtask

  task automatic t_id_idle();
    int t0;
    t0 = int'(track);
    @(negedge clk);
    id_valid = 1'b1; id_track = 8'd99; id_crc_ok = 1'b1;
    repeat (3) @(negedge clk);
    chk(id_ready == 1'b0 && busy == 1'b0, "R11 field not taken while idle", int'(id_ready), 0);
    chk(int'(track) == t0 && seek_err == 1'b0, "R11 idle field no effect", int'(track), t0);
    id_valid = 1'b0;
  endtask

  task automatic t_verify();
    pos = 2;
    write_trk(2);
    target_trk = 8'd3;
    do_cmd(1, 0, 0, 1, 0);
    wait_ready();
    chk(id_ready == 1'b1 && pulses == 1, "R11 ready after movement", int'(id_ready), 1);
    present_id(3, 1'b1);
    wait_done();
    chk(seek_err == 1'b0 && crc_err == 1'b0 && irq == 1'b1, "R9 verify match", int'(seek_err), 0);
    do_cmd(3, 1, 0, 1, 0);
    wait_ready();
    present_id(7, 1'b1);
    wait_done();
    chk(seek_err == 1'b1, "R9 verify mismatch", int'(seek_err), 1);
    do_cmd(4, 0, 0, 1, 0);
    wait_ready();
    present_id(4, 1'b0);
    chk(busy == 1'b1 && crc_err == 1'b1, "R10 bad CRC keeps waiting", int'(crc_err), 1);
    present_id(4, 1'b1);
    wait_done();
    chk(seek_err == 1'b0 && crc_err == 1'b1, "R10 retry past bad CRC", int'(seek_err), 0);
  endtask

  task automatic t_timeout();
    do_cmd(2, 0, 0, 1, 0);
    wait_ready();
    for (int i = 0; i < 3; i++) index_pulse();
    chk(busy == 1'b1, "R10 three revolutions still waiting", int'(busy), 1);
    index_pulse();
    wait_done();
    chk(seek_err == 1'b1 && irq == 1'b1, "R10 four revolution timeout", int'(seek_err), 1);
  endtask

  task automatic t_same_cycle();
    do_cmd(2, 0, 0, 1, 0);
    wait_ready();
    for (int i = 0; i < 3; i++) index_pulse();
    @(negedge clk);
    index_raw = 1'b1;
    repeat (3) @(negedge clk);
    id_valid = 1'b1; id_track = track; id_crc_ok = 1'b1;
    chk(id_ready == 1'b1, "R10 still waiting at fourth edge", int'(id_ready), 1);
    @(posedge clk);
    @(negedge clk);
    id_valid = 1'b0; index_raw = 1'b0;
    wait_done();
    chk(seek_err == 1'b0 && busy == 1'b0, "R10 field wins over timeout", int'(seek_err), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_restore_at_zero();
    t_restore_steps();
    t_restore_fail();
    t_seek();
    t_bad_op();
    t_single_steps();
    t_id_idle();
    t_verify();
    t_timeout();
    t_same_cycle();
    chk(setup_bad == 0, "R2 direction setup before pulse", setup_bad, 0);
    chk(dirchg_bad == 0, "R2 direction change during pulse", dirchg_bad, 0);
    summary();
    $finish;
  end

endmodule